// File: doc/BRIEF.md
# Endian-Aware Load/Store Byte Steering Unit

This unit sits between a processor's register file and a 32-bit memory bus and moves operands between the two. On the store side it takes a register value, an access size (byte, half-word or word), the two low address bits and a byte-reverse request. From these it produces the 32-bit bus write data and one enable per byte lane. It does this in the same cycle, with no registers on the path. On the load side it takes the 32-bit bus read data with the same controls. One cycle after a read-valid strobe it returns the operand right-justified and zero-filled in a 32-bit register value.

A one-bit attribute register holds the memory region's byte order and is cleared to big endian by reset. The byte order used for an access is the exclusive-OR of that attribute and the byte-reverse request. A byte-reverse access to a little-endian region therefore behaves as a plain big-endian one. The bus uses MSB-first lane numbering: lane 0 is bits 31:24 and is selected by address offset 0. Accesses that would run past the end of the 32-bit word are not split here. They raise a flag and enable no lanes, so that logic upstream can break them up.

Top module: `lsu_byte_steer`

## Requirements
- R1: After reset the region attribute `region_le` reads 0 (big endian), `ld_valid` is 0 and `ld_result` is 0. A write with `attr_wr_en`=1 loads `attr_le` into the attribute at the next clock edge, and later accesses use the new value.
- R2: Size is encoded in `acc_size` as 00 byte, 01 half-word, 10 word; 11 is illegal. For a legal size of n bytes at offset `addr_lo`=a with a+n<=4, `bus_be` bit k is 1 exactly for a<=k<a+n. Bit k corresponds to offset k, and offset k is carried on bus lane k, which is bits [31-8k:24-8k].
- R3: With effective byte order big endian, a store puts the operand's most significant byte at offset a and the following bytes at increasing offsets. A load assembles the operand from the lanes in the same way.
- R4: With effective byte order little endian, a store puts the operand's least significant byte at offset a and the more significant bytes at increasing offsets. A load assembles the operand from the lanes in the same way.
- R5: A byte access takes bits 7:0 of the register and places them on lane a, or loads lane a into bits 7:0. This holds whatever the byte order.
- R6: The effective byte order is little endian when `region_le` XOR `byte_rev` is 1, and big endian otherwise. `byte_rev` never changes `region_le`.
- R7: Operands are right-justified in the register: only the low n bytes of `st_data` are used, and `ld_result` holds zeros above the low n bytes, with no sign extension. Bus lanes that are not enabled are driven to zero on `bus_wdata`.
- R8: Unaligned half-words and words that stay within the word are legal. If a+n>4 or the size is illegal, `misaligned` is 1, `bus_be` is 0000 and `bus_wdata` is 0, and a load under those controls returns 0.
- R9: `ld_valid` is 1 in the cycle after `rd_valid` was 1 and 0 otherwise. `ld_result` changes only on a cycle after `rd_valid`, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| attr_wr_en | input | 1 | Write strobe for the region attribute |
| attr_le | input | 1 | New attribute value, 1 = little endian |
| region_le | output | 1 | Current region attribute |
| acc_size | input | 2 | Access size code |
| addr_lo | input | 2 | Byte offset within the word |
| byte_rev | input | 1 | Byte-reverse access request |
| st_data | input | 32 | Register value to store |
| bus_wdata | output | 32 | Steered bus write data |
| bus_be | output | 4 | Lane enables, bit k = offset k |
| misaligned | output | 1 | Access crosses the word or size illegal |
| rd_valid | input | 1 | Bus read data valid this cycle |
| bus_rdata | input | 32 | Bus read data |
| ld_valid | output | 1 | Load result valid |
| ld_result | output | 32 | Right-justified, zero-filled load operand |

## Verification
The bench covers the offsets where a half-word or word just fits (half at 2, word at 0) and where it just fails to fit (half at 3, word at 1 to 3). A design with an off-by-one boundary would enable lanes past lane 3 or refuse a legal unaligned half-word. It pairs byte-reverse with both attribute values. A design that ORs the two controls instead of XORing them would leave a reversed access to a little-endian region byte-swapped. Load results are compared for stale upper bytes, since a missing zero-fill or sign extension shows up only on byte and half-word loads with set upper bits. The attribute is written in the middle of a stream to catch a design that uses the new value a cycle early.

// File: rtl/lsu_steer_pkg.sv
package lsu_steer_pkg;

    parameter int LANE_W    = 8;
    parameter int NUM_LANES = 4;
    localparam int WORD_W   = LANE_W * NUM_LANES;
    localparam int OFF_W    = $clog2(NUM_LANES);
    localparam int CNT_W    = OFF_W + 1;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'b00,
        ACC_HALF = 2'b01,
        ACC_WORD = 2'b10,
        ACC_BAD  = 2'b11
    } acc_size_e;

    typedef struct packed {
        acc_size_e          size;
        logic [OFF_W-1:0]   off;
        logic               swap;   // 1: least significant byte at lowest offset
    } steer_ctl_t;

    // Number of bytes moved by an access; zero for the illegal code.
    function automatic logic [CNT_W-1:0] size_bytes(acc_size_e s);
        case (s)
            ACC_BYTE: size_bytes = CNT_W'(1);
            ACC_HALF: size_bytes = CNT_W'(2);
            ACC_WORD: size_bytes = CNT_W'(4);
            default:  size_bytes = '0;
        endcase
    endfunction

    // True when the access cannot be served inside one bus word.
    function automatic logic access_bad(acc_size_e s, logic [OFF_W-1:0] off);
        logic [CNT_W:0] last;
        last = {2'b00, off} + {1'b0, size_bytes(s)};
        access_bad = (size_bytes(s) == '0) || (last > (CNT_W+1)'(NUM_LANES));
    endfunction

    // Bit slice of lane k, lane 0 being the most significant byte.
    function automatic logic [LANE_W-1:0] lane_of(logic [WORD_W-1:0] w, int k);
        lane_of = w[WORD_W-1-k*LANE_W -: LANE_W];
    endfunction

endpackage

// File: rtl/lsu_endian_attr.sv
module lsu_endian_attr (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_le,
    output logic le_q
);
    always_ff @(posedge clk) begin
        if (rst)        le_q <= 1'b0;
        else if (wr_en) le_q <= wr_le;
    end

    AST_ATTR_RESET_BE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !le_q);                                        // R1
    AST_ATTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) && !$past(rst) |-> $stable(le_q));              // R6
endmodule

// File: rtl/lsu_store_map.sv
module lsu_store_map
    import lsu_steer_pkg::*;
(
    input  steer_ctl_t          ctl,
    input  logic [WORD_W-1:0]   st_data,
    output logic [WORD_W-1:0]   wdata,
    output logic [NUM_LANES-1:0] be,
    output logic                bad
);
    logic [CNT_W-1:0] nbytes;

    assign nbytes = size_bytes(ctl.size);
    assign bad    = access_bad(ctl.size, ctl.off);

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        logic [CNT_W-1:0] rel;
        logic [CNT_W-1:0] src;
        logic             hit;

        always_comb begin
            rel = CNT_W'(k) - {1'b0, ctl.off};
            hit = !bad && (CNT_W'(k) >= {1'b0, ctl.off}) && (rel < nbytes);
            src = ctl.swap ? rel : (nbytes - CNT_W'(1) - rel);
            be[k] = hit;
            wdata[WORD_W-1-k*LANE_W -: LANE_W] =
                hit ? st_data[src[OFF_W-1:0]*LANE_W +: LANE_W] : '0;
        end
    end

    always_comb begin
        if (bad) AST_BAD_NO_LANES: assert (be == '0);                // R8
    end
endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align
    import lsu_steer_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_valid,
    input  steer_ctl_t          ctl,
    input  logic [WORD_W-1:0]   rdata,
    output logic                res_valid,
    output logic [WORD_W-1:0]   res_q
);
    logic [CNT_W-1:0]  nbytes;
    logic              bad;
    logic [WORD_W-1:0] aligned;

    assign nbytes = size_bytes(ctl.size);
    assign bad    = access_bad(ctl.size, ctl.off);

    for (genvar j = 0; j < NUM_LANES; j++) begin : g_byte
        logic [CNT_W-1:0] lane;
        logic             used;

        always_comb begin
            used = !bad && (CNT_W'(j) < nbytes);
            lane = ctl.swap ? ({1'b0, ctl.off} + CNT_W'(j))
                            : ({1'b0, ctl.off} + nbytes - CNT_W'(1) - CNT_W'(j));
            aligned[j*LANE_W +: LANE_W] =
                used ? lane_of(rdata, int'(lane[OFF_W-1:0])) : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_q     <= '0;
        end else begin
            res_valid <= rd_valid;
            if (rd_valid) res_q <= aligned;
        end
    end

    AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_valid) && !$past(rst) |-> $stable(res_q));          // R9
endmodule

// File: rtl/lsu_byte_steer.sv
module lsu_byte_steer
    import lsu_steer_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  attr_wr_en,
    input  logic                  attr_le,
    output logic                  region_le,
    input  logic [1:0]            acc_size,
    input  logic [OFF_W-1:0]      addr_lo,
    input  logic                  byte_rev,
    input  logic [WORD_W-1:0]     st_data,
    output logic [WORD_W-1:0]     bus_wdata,
    output logic [NUM_LANES-1:0]  bus_be,
    output logic                  misaligned,
    input  logic                  rd_valid,
    input  logic [WORD_W-1:0]     bus_rdata,
    output logic                  ld_valid,
    output logic [WORD_W-1:0]     ld_result
);
    steer_ctl_t ctl;

    lsu_endian_attr u_attr (
        .clk   (clk),
        .rst   (rst),
        .wr_en (attr_wr_en),
        .wr_le (attr_le),
        .le_q  (region_le)
    );

    always_comb begin
        ctl.size = acc_size_e'(acc_size);
        ctl.off  = addr_lo;
        ctl.swap = region_le ^ byte_rev;
    end

    lsu_store_map u_store (
        .ctl     (ctl),
        .st_data (st_data),
        .wdata   (bus_wdata),
        .be      (bus_be),
        .bad     (misaligned)
    );

    lsu_load_align u_load (
        .clk       (clk),
        .rst       (rst),
        .rd_valid  (rd_valid),
        .ctl       (ctl),
        .rdata     (bus_rdata),
        .res_valid (ld_valid),
        .res_q     (ld_result)
    );

    AST_BE_COUNT: assert property (@(posedge clk) disable iff (rst)
        !misaligned |-> $countones(bus_be) == int'(size_bytes(acc_size_e'(acc_size)))); // R2
    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
        acc_size == 2'b00 |-> bus_be[addr_lo] && $onehot0(bus_be));  // R5
    AST_LD_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> ld_valid);                                       // R9
    AST_LD_BYTE_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
        rd_valid && acc_size == 2'b00 |=> ld_result[WORD_W-1:LANE_W] == '0); // R7
    AST_BAD_WDATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        misaligned |-> bus_wdata == '0);                              // R8
endmodule

// File: tb/tb_lsu_byte_steer.sv
`timescale 1ns/1ps
module tb_lsu_byte_steer;
    logic        clk = 1'b0;
    logic        rst;
    logic        attr_wr_en, attr_le, region_le;
    logic [1:0]  acc_size, addr_lo;
    logic        byte_rev;
    logic [31:0] st_data, bus_wdata, bus_rdata, ld_result;
    logic [3:0]  bus_be;
    logic        misaligned, rd_valid, ld_valid;

    int checks = 0;
    int errors = 0;

    // model state
    bit          m_le = 0;
    bit          pend_v = 0;
    logic [31:0] pend_res = 0;
    logic [31:0] m_ld = 0;
    string       pend_tag = "R9";

    always #5 clk = ~clk;

    lsu_byte_steer dut (
        .clk(clk), .rst(rst), .attr_wr_en(attr_wr_en), .attr_le(attr_le),
        .region_le(region_le), .acc_size(acc_size), .addr_lo(addr_lo),
        .byte_rev(byte_rev), .st_data(st_data), .bus_wdata(bus_wdata),
        .bus_be(bus_be), .misaligned(misaligned), .rd_valid(rd_valid),
        .bus_rdata(bus_rdata), .ld_valid(ld_valid), .ld_result(ld_result)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int nbytes_of(logic [1:0] s);
        case (s)
            2'b00: return 1;
            2'b01: return 2;
            2'b10: return 4;
            default: return 0;
        endcase
    endfunction

    // One cycle: check the load due now, drive inputs, check the store side.
    task automatic step(bit we, bit wle, logic [1:0] sz, logic [1:0] off,
                        bit brv, logic [31:0] sd, bit rv, logic [31:0] rd,
                        string tag);
        int n; bit swp; bit bad;
        logic [31:0] ew; logic [3:0] eb; logic [31:0] er;
        @(negedge clk);
        check("R9 ld_valid", {31'b0, ld_valid}, {31'b0, pend_v});
        if (pend_v) m_ld = pend_res;
        check({pend_tag, " ld_result"}, ld_result, m_ld);
        check("R1 region_le", {31'b0, region_le}, {31'b0, m_le});
        attr_wr_en = we; attr_le = wle; acc_size = sz; addr_lo = off;
        byte_rev = brv; st_data = sd; rd_valid = rv; bus_rdata = rd;
        #1;
        n = nbytes_of(sz);
        swp = m_le ^ brv;
        bad = (n == 0) || (int'(off) + n > 4);
        ew = 0; eb = 0; er = 0;
        if (!bad) begin
            for (int i = 0; i < n; i++) begin
                int lane = int'(off) + i;
                int sig  = swp ? i : n - 1 - i;
                eb[lane] = 1'b1;
                ew[31 - 8*lane -: 8] = sd[8*sig +: 8];
                er[8*sig +: 8] = rd[31 - 8*lane -: 8];
            end
        end
        check({tag, " R3/R4 bus_wdata"}, bus_wdata, ew);
        check({tag, " R2 bus_be"}, {28'b0, bus_be}, {28'b0, eb});
        check({tag, " R8 misaligned"}, {31'b0, misaligned}, {31'b0, bad});
        pend_v = rv; pend_res = er; pend_tag = tag;
        if (we) m_le = wle;
    endtask

    initial begin
        rst = 1'b1;
        attr_wr_en = 0; attr_le = 0; acc_size = 0; addr_lo = 0; byte_rev = 0;
        st_data = 0; rd_valid = 0; bus_rdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1: reset state
        check("R1 reset region_le", {31'b0, region_le}, 32'd0);
        check("R1 reset ld_valid", {31'b0, ld_valid}, 32'd0);
        check("R1 reset ld_result", ld_result, 32'd0);

        // R3 big-endian word, aligned
        step(0,0,2'b10,2'd0,0,32'h11223344,1,32'hA1B2C3D4,"R3");
        // R3 big-endian half at offset 2, and unaligned half at offset 1
        step(0,0,2'b01,2'd2,0,32'hFFFF1122,1,32'h0000BEEF,"R3");
        step(0,0,2'b01,2'd1,0,32'h00005566,1,32'h12345678,"R3");
        // R5 bytes at each offset, R7 zero-fill on load
        for (int o = 0; o < 4; o++)
            step(0,0,2'b00,2'(o),0,32'hCAFE0011 + o,1,32'h8899AABB,"R5");
        // R8 crossing accesses and the illegal size
        step(0,0,2'b01,2'd3,0,32'h1234,1,32'hFFFFFFFF,"R8");
        for (int o = 1; o < 4; o++)
            step(0,0,2'b10,2'(o),0,32'hDEADBEEF,1,32'hFFFFFFFF,"R8");
        step(0,0,2'b11,2'd0,0,32'hDEADBEEF,1,32'hFFFFFFFF,"R8");
        // R6 byte-reverse in a big-endian region
        step(0,0,2'b10,2'd0,1,32'h11223344,1,32'h44332211,"R6");
        // R1 program little endian; applies from the next access
        step(1,1,2'b10,2'd0,0,32'h11223344,0,32'h0,"R1");
        // R4 little-endian word, half at 2, half at 0, byte
        step(0,0,2'b10,2'd0,0,32'h11223344,1,32'h44332211,"R4");
        step(0,0,2'b01,2'd2,0,32'h00001122,1,32'h00002211,"R4");
        step(0,0,2'b01,2'd0,0,32'h00001122,1,32'h2211FFFF,"R4");
        step(0,0,2'b00,2'd3,0,32'h00000077,1,32'hFFFFFF77,"R5");
        // R6 byte-reverse in a little-endian region acts as big endian
        step(0,0,2'b10,2'd0,1,32'h11223344,1,32'h11223344,"R6");
        step(0,0,2'b01,2'd1,1,32'h0000AABB,0,32'h0,"R6");
        // R9 idle cycles hold the result
        step(0,0,2'b10,2'd0,0,32'h0,0,32'h5A5A5A5A,"R9");
        step(0,0,2'b10,2'd0,0,32'h0,0,32'h5A5A5A5A,"R9");
        // random stream mixing everything
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r = $urandom;
            step(r[0] & r[1] & r[2], r[3], r[5:4], r[7:6], r[8], $urandom,
                 r[9], $urandom, "R2/R3/R4/R7");
        end
        step(0,0,2'b00,2'd0,0,32'h0,0,32'h0,"R9");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule